// File: doc/BRIEF.md
# Indexed PLL Configuration Register Bridge

This block holds the configuration words of a clock generator in a file of up to 64 words of 32 bits. A host reaches that file only indirectly, through a small window of host registers. The host first writes a selector word that holds the target word number, a write-permission flag and a divider-choice field. It then reads or writes the data window, and the bridge applies that access to the selected word.

A separate divider-choice window lets the host change the divider field alone, without touching the word number or the permission flag. A sequencer client has its own port for a masked read-modify-write. That port updates one word in a single cycle: it keeps the bits where the mask is one and ORs in the new value. The analog PLL is not part of this block.

Top module: `pll_index_bridge`

## Requirements
- R1: After a synchronous reset, every configuration word, the selector word and `bus_rdata` are zero.
- R2: A host write to window 0 loads the selector fields from `bus_wdata`: the word number from bits [5:0], the write-permission flag from bit 7 and the divider choice from bits [9:8]. A read of window 0 returns those fields in the same positions, with all other bits zero.
- R3: A host write to window 1 while the permission flag is set stores `bus_wdata` in the selected word.
- R4: A host write to window 1 while the permission flag is clear leaves every configuration word unchanged.
- R5: A host read of window 1 places the selected word on `bus_rdata` at the clock edge that samples `bus_rd`. The value holds until the next read.
- R6: A host write to window 2 loads only the divider choice, from `bus_wdata[9:8]`. The word number and the permission flag keep their values.
- R7: A sequencer request sets word `seq_addr` to `(old & seq_mask) | seq_val` at the sampling edge, and `seq_done` is high for the following cycle.
- R8: If a sequencer request and a permitted host write to window 1 fall in the same cycle, the sequencer update is applied and the host write is dropped.
- R9: Window 3 reads as zero, and writes to it change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 2 | Host window: 0 selector, 1 data, 2 divider choice, 3 unused |
| bus_wr | input | 1 | Host write strobe |
| bus_rd | input | 1 | Host read strobe |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Host read data, valid the cycle after `bus_rd` |
| seq_req | input | 1 | Sequencer masked-update request |
| seq_addr | input | 6 | Sequencer target word |
| seq_val | input | 32 | Bits ORed into the target word |
| seq_mask | input | 32 | Bits of the old word that are kept |
| seq_done | output | 1 | High the cycle after a sequencer request |

## Verification
The assertions take for granted that the host never raises `bus_wr` and `bus_rd` in the same cycle. They also take for granted that the host never writes the selector in the same cycle as a data-window access, so that the selected word is fixed across each checked cycle. The stimulus drives one strobe per transaction and returns it low for a cycle in between. The one sequencer collision case is deliberate and points both writers at the same word, which keeps the conflict check meaningful.

// File: rtl/pll_index_bridge.sv
module pll_index_bridge #(
  parameter int AW      = 6,
  parameter int DW      = 32,
  parameter int DIVW    = 2,
  parameter int WE_BIT  = 7,
  parameter int DIV_LSB = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          seq_req,
  input  logic [AW-1:0] seq_addr,
  input  logic [DW-1:0] seq_val,
  input  logic [DW-1:0] seq_mask,
  output logic          seq_done
);
  localparam int DEPTH = 1 << AW;
  localparam logic [1:0] WIN_IDX = 2'd0, WIN_DATA = 2'd1, WIN_DIV = 2'd2;

  logic [DW-1:0]   rf [DEPTH];
  logic [AW-1:0]   idx_addr;
  logic            idx_we;
  logic [DIVW-1:0] idx_div;
  logic [DW-1:0]   idx_word;

  wire            host_data_wr = bus_wr && bus_addr == WIN_DATA && idx_we;
  wire [DW-1:0]   sel_word     = rf[idx_addr];
  wire [DW-1:0]   seq_new      = (rf[seq_addr] & seq_mask) | seq_val;

  always_comb begin
    idx_word                    = '0;
    idx_word[AW-1:0]            = idx_addr;
    idx_word[WE_BIT]            = idx_we;
    idx_word[DIV_LSB +: DIVW]   = idx_div;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) rf[i] <= '0;
    end else if (seq_req) begin
      rf[seq_addr] <= seq_new;
    end else if (host_data_wr) begin
      rf[idx_addr] <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_addr <= '0;
      idx_we   <= 1'b0;
      idx_div  <= '0;
    end else if (bus_wr) begin
      if (bus_addr == WIN_IDX) begin
        idx_addr <= bus_wdata[AW-1:0];
        idx_we   <= bus_wdata[WE_BIT];
        idx_div  <= bus_wdata[DIV_LSB +: DIVW];
      end else if (bus_addr == WIN_DIV) begin
        idx_div  <= bus_wdata[DIV_LSB +: DIVW];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      seq_done  <= 1'b0;
    end else begin
      seq_done <= seq_req;
      if (bus_rd) begin
        case (bus_addr)
          WIN_IDX:  bus_rdata <= idx_word;
          WIN_DATA: bus_rdata <= sel_word;
          default:  bus_rdata <= '0;
        endcase
      end
    end
  end

  AST_WE_GATES_WRITE: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == WIN_DATA && !idx_we && !seq_req) |=> $stable(sel_word)); // R4
  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == WIN_DATA && idx_we && !seq_req) |=> sel_word == $past(bus_wdata)); // R3
  AST_READ_DATA: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == WIN_DATA) |=> bus_rdata == $past(sel_word)); // R5
  AST_DIV_KEEPS_INDEX: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == WIN_DIV) |=> $stable(idx_addr) && $stable(idx_we)); // R6
  AST_SEQ_DONE: assert property (@(posedge clk) disable iff (rst)
    seq_req |=> seq_done); // R7
  AST_SEQ_WINS: assert property (@(posedge clk) disable iff (rst)
    (seq_req && host_data_wr && seq_addr == idx_addr) |=> sel_word == $past(seq_new)); // R8
  AST_UNUSED_READ: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == 2'd3) |=> bus_rdata == '0); // R9
endmodule

// File: tb/pll_index_bridge_tb.sv
module pll_index_bridge_tb;
  logic        clk = 0, rst = 1;
  logic [1:0]  bus_addr = '0;
  logic        bus_wr = 0, bus_rd = 0, seq_req = 0;
  logic [31:0] bus_wdata = '0, seq_val = '0, seq_mask = '0;
  logic [5:0]  seq_addr = '0;
  logic [31:0] bus_rdata;
  logic        seq_done;
  int tests = 0, fails = 0;

  always #2 clk = ~clk;

  pll_index_bridge u_dut (.clk, .rst, .bus_addr, .bus_wr, .bus_rd, .bus_wdata,
    .bus_rdata, .seq_req, .seq_addr, .seq_val, .seq_mask, .seq_done);

  typedef struct packed { logic rd; logic [1:0] a; logic [31:0] d; } vec_t;
  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 2'd0, 32'h0000_0085}, '{1'b1, 2'd0, 32'h0000_0085},
    '{1'b0, 2'd1, 32'hDEAD_BEEF}, '{1'b1, 2'd1, 32'hDEAD_BEEF},
    '{1'b0, 2'd0, 32'h0000_0005}, '{1'b0, 2'd1, 32'h1234_5678},
    '{1'b1, 2'd1, 32'hDEAD_BEEF}, '{1'b0, 2'd2, 32'hFFFF_FFFF},
    '{1'b1, 2'd0, 32'h0000_0305}, '{1'b0, 2'd0, 32'hFFFF_FCBF},
    '{1'b1, 2'd0, 32'h0000_00BF}, '{1'b0, 2'd1, 32'hA5A5_0001},
    '{1'b1, 2'd1, 32'hA5A5_0001}, '{1'b0, 2'd3, 32'hFFFF_FFFF},
    '{1'b1, 2'd3, 32'h0000_0000}
  };
  localparam string VTAG [NV] = '{"R2", "R2", "R3", "R5", "R2", "R4", "R4", "R6",
                                   "R6", "R2", "R2", "R3", "R5", "R9", "R9"};

  task automatic check(input string tag, input logic [31:0] act, exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic do_rd(input logic [1:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); bus_addr = a; bus_rd = 1;
    @(negedge clk); bus_rd = 0;
    check(tag, bus_rdata, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    check("R1", bus_rdata, 32'h0);
    do_rd(2'd0, 32'h0, "R1");
    do_rd(2'd1, 32'h0, "R1");

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].rd) do_rd(VEC[i].a, VEC[i].d, VTAG[i]);
      else do_wr(VEC[i].a, VEC[i].d);
    end

    // R7: masked update of word 5
    do_wr(2'd0, 32'h0000_0085);
    @(negedge clk); seq_req = 1; seq_addr = 6'd5; seq_mask = 32'hFFFF_0000; seq_val = 32'h0000_1234;
    @(negedge clk); seq_req = 0;
    check("R7", {31'b0, seq_done}, 32'h1);
    @(negedge clk);
    check("R7", {31'b0, seq_done}, 32'h0);
    do_rd(2'd1, 32'hDEAD_1234, "R7");

    // R8: sequencer and host write collide on word 5
    @(negedge clk);
    seq_req = 1; seq_addr = 6'd5; seq_mask = 32'h0; seq_val = 32'h0000_0011;
    bus_addr = 2'd1; bus_wdata = 32'h0000_0099; bus_wr = 1;
    @(negedge clk); seq_req = 0; bus_wr = 0;
    do_rd(2'd1, 32'h0000_0011, "R8");

    // R1: reset clears the file and the selector
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    check("R1", bus_rdata, 32'h0);
    do_rd(2'd0, 32'h0, "R1");
    do_wr(2'd0, 32'h0000_0005);
    do_rd(2'd1, 32'h0, "R1");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule